// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software sets up two registers, a mode word and a timing word. Each of them changes only when the write also carries a register-specific key pattern, so a stray store cannot turn the watchdog off or stretch its timeout.

While the watchdog runs, a clock divider produces ticks and each tick lowers a down-counter. Software keeps the system alive by writing one exact magic word to the kick register. That write reloads the counter from the programmed timeout. If the counter reaches zero first, the block sets a sticky status flag. It can also drive a reset pulse of programmable length, raise a sticky interrupt, or do both.

A typical setup sequence is:
1. Write the timing word with its key.
2. Write the mode word with its key.
3. Kick the counter.

After that, software kicks periodically.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the mode register reads 0x0000_0000, the timing register reads 0x0000_3FFF (reload 0xFFF, divider select 3), status reads 0, and both `irq_o` and `rst_pulse_o` are low.
- R2: A write to offset 0x0 updates the mode fields only when bits [23:12] of the data equal 0xABC. The mode fields are: bit 0 run, bit 1 reset-pulse enable, bit 2 interrupt enable, bits [5:4] pulse-length code. A read returns only these fields, with every other bit (including the key bits) reading 0. A write with any other key leaves the register unchanged.
- R3: A write to offset 0x4 updates the timing fields only when bits [25:14] equal 0x248. The timing fields are: bits [1:0] divider select and bits [13:2] reload value. A read returns only these fields. A write with any other key leaves the register unchanged.
- R4: The divider select maps to tick periods of 8, 64, 512 and 4096 clocks for codes 0, 1, 2 and 3.
- R5: A write of exactly 0x0000_1999 to offset 0x8 loads the counter with reload × 2^LOW_W and restarts the divider. With run set, expiry follows exactly reload × 2^LOW_W × period clock edges after that write's edge.
- R6: A write of any other value to offset 0x8 has no effect: it does not reload the counter, clear the status or clear the interrupt.
- R7: While run is clear, the divider is held at zero and the counter keeps its value. Setting run again resumes the countdown.
- R8: Expiry happens when the counter steps from 1 to 0. It sets status bit 0, read at offset 0xC. Bus writes do not change this bit; only a valid kick clears it.
- R9: On expiry with reset-pulse enable set, `rst_pulse_o` goes high for 2, 4, 8 or 16 clocks for pulse-length codes 0, 1, 2 and 3.
- R10: On expiry with interrupt enable set, `irq_o` goes high and stays high until a valid kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_pulse_o | output | 1 | Timed reset pulse on expiry |
| irq_o | output | 1 | Sticky expiry interrupt |

## Verification
Register writes and kicks take effect at the clock edge that samples the strobe. Reads are combinational, so a read value is due in the same cycle as its address. Expiry, the status flag, the interrupt and the first cycle of the reset pulse all appear at the edge that ends the final tick, exactly reload × 2^LOW_W × period edges after the kick edge. The pulse then lasts its coded length. The bench steps a behavioural model on the same edges and compares all outputs a little after every falling edge. It also counts edges from each kick edge to the rising output and compares that count against the formula.

// File: rtl/kwdt_pkg.sv
// Package: shared constants and register field types for the watchdog.
// Assumes a 4-bit byte address with word-aligned registers.
package kwdt_pkg;
    localparam int RLD_W  = 12;   // reload field width
    localparam int PRE_W  = 12;   // divider counter width (max period 4096)
    localparam int PLS_W  = 5;    // pulse counter width (max 16)

    localparam logic [1:0]  WORD_MODE = 2'd0;
    localparam logic [1:0]  WORD_TIME = 2'd1;
    localparam logic [1:0]  WORD_KICK = 2'd2;
    localparam logic [1:0]  WORD_STAT = 2'd3;

    localparam logic [11:0] MODE_KEY  = 12'hABC;
    localparam logic [11:0] TIME_KEY  = 12'h248;
    localparam logic [31:0] KICK_WORD = 32'h0000_1999;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       run;
    } mode_t;

    typedef struct packed {
        logic [RLD_W-1:0] reload;
        logic [1:0]       div_sel;
    } time_t;
endpackage

// File: rtl/kwdt_regs.sv
// Register file: key-checked mode and timing registers, kick detection and
// the combinational read mux. Assumes single-cycle write strobes.
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    input  logic        stat_i,
    output mode_t       mode_o,
    output time_t       time_o,
    output logic        kick_o,
    output logic [31:0] bus_rdata
);
    logic [1:0] word;
    logic       mode_wr;
    logic       time_wr;

    // Decode the register word and qualify each write with its key.
    always_comb begin
        word    = bus_addr[3:2];
        mode_wr = bus_we && (word == WORD_MODE) && (bus_wdata[23:12] == MODE_KEY);
        time_wr = bus_we && (word == WORD_TIME) && (bus_wdata[25:14] == TIME_KEY);
        kick_o  = bus_we && (word == WORD_KICK) && (bus_wdata == KICK_WORD);
    end

    // Mode register: keyed update of run, enables and pulse code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
        end else if (mode_wr) begin
            mode_o.plen   <= bus_wdata[5:4];
            mode_o.irq_en <= bus_wdata[2];
            mode_o.rst_en <= bus_wdata[1];
            mode_o.run    <= bus_wdata[0];
        end
    end

    // Timing register: keyed update of reload value and divider select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_o.reload  <= '1;
            time_o.div_sel <= 2'd3;
        end else if (time_wr) begin
            time_o.reload  <= bus_wdata[13:2];
            time_o.div_sel <= bus_wdata[1:0];
        end
    end

    // Read mux: stored fields only, keys and unused bits read as zero.
    always_comb begin
        bus_rdata = '0;
        case (word)
            WORD_MODE: bus_rdata[5:0] = {mode_o.plen, 1'b0, mode_o.irq_en,
                                         mode_o.rst_en, mode_o.run};
            WORD_TIME: bus_rdata[RLD_W+1:0] = {time_o.reload, time_o.div_sel};
            WORD_STAT: bus_rdata[0] = stat_i;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_prescale.sv
// Clock divider: emits a one-cycle tick every 8/64/512/4096 clocks per the
// select code. Held at zero while stopped and restarted by a kick.
module kwdt_prescale
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    // Terminal count for the selected period.
    always_comb begin
        case (div_sel)
            2'd0:    last = PRE_W'(7);
            2'd1:    last = PRE_W'(63);
            2'd2:    last = PRE_W'(511);
            default: last = PRE_W'(4095);
        endcase
        tick = run && (pre_q == last);
    end

    // Divider counter: wrap on tick, clear when stopped or kicked.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear || tick) pre_q <= '0;
        else                                 pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/kwdt_counter.sv
// Down-counter: reloads to reload*2^LOW_W on a kick, steps down on each tick
// and flags expiry on the 1-to-0 step. Parks at zero until the next kick.
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int LOW_W = 12,
    localparam int CNT_W = RLD_W + LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             kick,
    input  logic [RLD_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    // Expiry strobe; a kick in the same cycle wins.
    always_comb expire_o = tick && (cnt_o == CNT_W'(1)) && !kick;

    // Counter register with reload priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_o <= {{RLD_W{1'b1}}, {LOW_W{1'b0}}};
        else if (kick)                 cnt_o <= {reload, {LOW_W{1'b0}}};
        else if (tick && cnt_o != '0)  cnt_o <= cnt_o - 1'b1;
    end
endmodule

// File: rtl/kwdt_signal.sv
// Expiry outputs: sticky status, sticky interrupt and a counted reset pulse.
// Assumes the expiry strobe is a single cycle.
module kwdt_signal
    import kwdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  expire,
    input  logic  kick,
    input  mode_t mode,
    output logic  stat_o,
    output logic  irq_o,
    output logic  rst_pulse_o
);
    logic [PLS_W-1:0] pls_q;

    // Status flag: set on expiry, cleared only by a valid kick.
    always_ff @(posedge clk) begin
        if (!rst_n || kick) stat_o <= 1'b0;
        else if (expire)    stat_o <= 1'b1;
    end

    // Interrupt: set on expiry when enabled, cleared by a valid kick.
    always_ff @(posedge clk) begin
        if (!rst_n || kick)            irq_o <= 1'b0;
        else if (expire && mode.irq_en) irq_o <= 1'b1;
    end

    // Pulse counter: load 2<<code on expiry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pls_q <= '0;
        else if (expire && mode.rst_en) pls_q <= PLS_W'(5'd2 << mode.plen);
        else if (pls_q != '0)           pls_q <= pls_q - 1'b1;
    end

    always_comb rst_pulse_o = (pls_q != '0);
endmodule

// File: rtl/kwdt_top.sv
// Top level: key-protected watchdog on a 32-bit register bus. LOW_W sets
// how many low counter bits sit below the 12-bit reload field.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int LOW_W = 12,
    localparam int CNT_W = RLD_W + LOW_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_pulse_o,
    output logic        irq_o
);
    mode_t            mode_q;
    time_t            time_q;
    logic             kick;
    logic             tick;
    logic             expire;
    logic             stat_w;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;

    always_comb run_w = mode_q.run;

    kwdt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .stat_i(stat_w), .mode_o(mode_q),
        .time_o(time_q), .kick_o(kick), .bus_rdata(bus_rdata)
    );

    kwdt_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_w), .clear(kick),
        .div_sel(time_q.div_sel), .tick(tick)
    );

    kwdt_counter #(.LOW_W(LOW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
        .reload(time_q.reload), .cnt_o(cnt_w), .expire_o(expire)
    );

    kwdt_signal u_sig (
        .clk(clk), .rst_n(rst_n), .expire(expire), .kick(kick), .mode(mode_q),
        .stat_o(stat_w), .irq_o(irq_o), .rst_pulse_o(rst_pulse_o)
    );
endmodule

// File: rtl/kwdt_checker.sv
// Checker: temporal properties of the watchdog outputs and internal state,
// attached to every kwdt_top instance by bind.
module kwdt_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic             irq_o,
    input logic             rst_pulse_o,
    input logic             run_w,
    input logic             stat_w,
    input logic [CNT_W-1:0] cnt_w
);
    logic kick_seen;
    always_comb kick_seen = bus_we && (bus_addr[3:2] == 2'd2) && (bus_wdata == 32'h0000_1999);

    // R1: outputs are quiet in the cycle after a reset edge.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!rst_pulse_o && !irq_o));

    // R10: the interrupt holds until a valid kick.
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !kick_seen) |=> irq_o);

    // R10: a valid kick drops the interrupt and the status flag.
    a_r10_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick_seen |=> (!irq_o && !stat_w));

    // R8: status stays set without a kick, whatever the bus writes.
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w && !kick_seen) |=> stat_w);

    // R7: the counter is frozen while stopped.
    a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !kick_seen) |=> $stable(cnt_w));

    // R9: every reset pulse lasts at least two cycles.
    a_r9_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse_o) |=> rst_pulse_o);
endmodule

bind kwdt_top kwdt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .irq_o(irq_o), .rst_pulse_o(rst_pulse_o),
    .run_w(run_w), .stat_w(stat_w), .cnt_w(cnt_w)
);

// File: tb/kwdt_top_tb_top.sv
// Bench: behavioural reference model stepped on every clock and compared
// after each falling edge, plus directed checks with edge-counted timing.
module kwdt_top_tb_top;
    localparam int LOW_W = 4;
    localparam int SCALE = 1 << LOW_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        rst_pulse_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    // model state
    int m_run, m_rsten, m_irqen, m_plen, m_rld, m_sel;
    int m_pre, m_cnt, m_stat, m_irq, m_pls;

    always #10 clk = ~clk;

    kwdt_top #(.LOW_W(LOW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_pulse_o(rst_pulse_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_rd(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return (m_plen << 4) | (m_irqen << 2) | (m_rsten << 1) | m_run;
            2'd1:    return (m_rld << 2) | m_sel;
            2'd3:    return m_stat;
            default: return 0;
        endcase
    endfunction

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        int  div;
        bit  kick, tick, exp_ev;
        if (!rst_n) begin
            m_run = 0; m_rsten = 0; m_irqen = 0; m_plen = 0; m_rld = 4095; m_sel = 3;
            m_pre = 0; m_cnt = 4095 * SCALE; m_stat = 0; m_irq = 0; m_pls = 0;
        end else begin
            div    = 8 << (3 * m_sel);
            kick   = bus_we && bus_addr == 4'h8 && bus_wdata == 32'h1999;
            tick   = (m_run != 0) && (m_pre == div - 1);
            exp_ev = tick && (m_cnt == 1) && !kick;
            if (m_pls > 0) m_pls = m_pls - 1;
            if (exp_ev && m_rsten != 0) m_pls = 2 << m_plen;
            if (kick) begin m_stat = 0; m_irq = 0; end
            else if (exp_ev) begin m_stat = 1; if (m_irqen != 0) m_irq = 1; end
            if (kick) m_cnt = m_rld * SCALE;
            else if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
            if (m_run == 0 || kick || tick) m_pre = 0; else m_pre = m_pre + 1;
            if (bus_we && bus_addr == 4'h0 && bus_wdata[23:12] == 12'hABC) begin
                m_run = bus_wdata[0]; m_rsten = bus_wdata[1];
                m_irqen = bus_wdata[2]; m_plen = bus_wdata[5:4];
            end
            if (bus_we && bus_addr == 4'h4 && bus_wdata[25:14] == 12'h248) begin
                m_sel = bus_wdata[1:0]; m_rld = bus_wdata[13:2];
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            #2;
            chk(bus_rdata == model_rd(bus_addr), "R8 read data", bus_rdata, model_rd(bus_addr));
            chk(rst_pulse_o == (m_pls > 0), "R9 reset pulse", rst_pulse_o, m_pls > 0);
            chk(irq_o == (m_irq != 0), "R10 interrupt", irq_o, m_irq);
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Count edges from the last kick edge until the chosen output rises.
    task automatic measure(input bit use_irq, input int exp, input string tag);
        int n = 0;
        while (!(use_irq ? irq_o : rst_pulse_o)) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic pulse_width(input int exp, input string tag);
        int w = 0;
        while (rst_pulse_o) begin
            @(posedge clk); w++;
            @(negedge clk);
        end
        chk(w == exp, tag, w, exp);
    endtask

    localparam logic [31:0] MK = 32'h00AB_C000;
    localparam logic [31:0] TK = 32'h0092_0000;
    localparam logic [31:0] KW = 32'h0000_1999;

    initial begin
        logic [31:0] v;
        bit seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1 reset state
        bus_read(4'h0, v); chk(v == 32'h0, "R1 mode after reset", v, 0);
        bus_read(4'h4, v); chk(v == 32'h3FFF, "R1 timing after reset", v, 32'h3FFF);
        bus_read(4'hC, v); chk(v == 32'h0, "R1 status after reset", v, 0);
        chk(!rst_pulse_o && !irq_o, "R1 outputs after reset", {rst_pulse_o, irq_o}, 0);

        // R2 wrong mode key ignored, right key accepted, key bits read zero
        bus_write(4'h0, 32'h00AB_D035);
        bus_read(4'h0, v); chk(v == 32'h0, "R2 bad key ignored", v, 0);
        bus_write(4'h0, MK | 32'h35);
        bus_read(4'h0, v); chk(v == 32'h35, "R2 keyed write readback", v, 32'h35);
        bus_write(4'h0, MK);

        // R3 wrong timing key ignored, right key accepted
        bus_write(4'h4, 32'h0091_0000 | (2 << 2));
        bus_read(4'h4, v); chk(v == 32'h3FFF, "R3 bad key ignored", v, 32'h3FFF);
        bus_write(4'h4, TK | (2 << 2) | 0);
        bus_read(4'h4, v); chk(v == 32'h8, "R3 keyed write readback", v, 32'h8);

        // R5 R4 interrupt timing: reload 2, period 8
        bus_write(4'h0, MK | 32'h05);
        bus_write(4'h8, KW);
        measure(1'b1, 2 * SCALE * 8, "R5 expiry edge count, divide by 8");
        bus_read(4'hC, v); chk(v == 32'h1, "R8 status set on expiry", v, 1);
        bus_write(4'hC, 32'h0);
        bus_read(4'hC, v); chk(v == 32'h1, "R8 status write ignored", v, 1);

        // R6 wrong kick word ignored
        bus_write(4'h8, 32'h0000_1998);
        bus_read(4'hC, v); chk(v == 32'h1, "R6 bad kick keeps status", v, 1);
        chk(irq_o == 1'b1, "R6 bad kick keeps interrupt", irq_o, 1);

        // R10 R8 valid kick clears
        bus_write(4'h8, KW);
        bus_read(4'hC, v); chk(v == 32'h0, "R8 kick clears status", v, 0);
        chk(irq_o == 1'b0, "R10 kick clears interrupt", irq_o, 0);

        // R9 pulse lengths
        bus_write(4'h0, MK | 32'h33);
        bus_write(4'h8, KW);
        measure(1'b0, 2 * SCALE * 8, "R5 reset pulse timing");
        pulse_width(16, "R9 pulse length code 3");
        bus_write(4'h0, MK | 32'h13);
        bus_write(4'h8, KW);
        measure(1'b0, 2 * SCALE * 8, "R5 reset pulse timing code 1");
        pulse_width(4, "R9 pulse length code 1");

        // R4 other divider codes, reload 1
        bus_write(4'h0, MK | 32'h03);
        bus_write(4'h4, TK | (1 << 2) | 1);
        bus_write(4'h8, KW);
        measure(1'b0, SCALE * 64, "R4 divide by 64");
        pulse_width(2, "R9 pulse length code 0");
        bus_write(4'h4, TK | (1 << 2) | 2);
        bus_write(4'h8, KW);
        measure(1'b0, SCALE * 512, "R4 divide by 512");
        bus_write(4'h4, TK | (1 << 2) | 3);
        bus_write(4'h8, KW);
        measure(1'b0, SCALE * 4096, "R4 divide by 4096");

        // R7 stop freezes the countdown
        bus_write(4'h4, TK | (2 << 2) | 0);
        bus_write(4'h8, KW);
        repeat (100) @(negedge clk);
        bus_write(4'h0, MK | 32'h02);
        seen = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (rst_pulse_o) seen = 1'b1;
        end
        chk(!seen, "R7 no expiry while stopped", seen, 0);
        bus_write(4'h0, MK | 32'h03);
        seen = 1'b0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (rst_pulse_o) seen = 1'b1;
        end
        chk(seen, "R7 countdown resumes", seen, 1);

        repeat (20) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule